// File: doc/BRIEF.md
# Teletext Line Insertion Controller

This block decides, line by line, whether serial teletext data goes into the video output. It also generates the timing that pulls that data in. A one-cycle line-start pulse arrives with the current line number and a field flag. The block compares the line against a programmable first/last line pair for the odd field and a second pair for the even field. On an eligible line it raises a data request a fixed number of pixel-clock cycles before the insertion window opens, so the source can present the first bit in time. It then opens a window that lasts exactly 360 teletext bits, clock run-in included.

Bit timing comes from a fractional phase accumulator clocked by the line-locked pixel clock. Each overflow of the accumulator is one bit strobe. The strobe goes to the downstream modulator and also samples the serial input into a data register. The window closes together with the 360th strobe. On lines outside the programmed ranges, request, window and strobe all stay low.

Top module: `ttx_line_inserter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `ttx_req`, `ttx_gate`, `bit_strobe` and `ttx_bit_out` are 0.
- R2: A line is eligible when `field_odd`=1 and `odd_first` <= `line_num` <= `odd_last`, or when `field_odd`=0 and `even_first` <= `line_num` <= `even_last`. Both ends of each range are inclusive. The test is made in the cycle where `line_start` is 1.
- R3: If a field's first line is greater than its last line, no line of that field is eligible.
- R4: On a line that is not eligible, `ttx_req`, `ttx_gate` and `bit_strobe` stay 0 until the next `line_start`.
- R5: Counting the clock edge that samples `line_start` as cycle 0, `ttx_req` first reads 1 after edge WIN_AT-REQ_LEAD of an eligible line. It stays 1 until the edge that registers the 360th strobe, where it falls.
- R6: On an eligible line, `ttx_gate` first reads 1 after edge WIN_AT. It stays 1 without a break up to and including the cycle of the 360th strobe, and then falls.
- R7: An ACC_W-bit accumulator is cleared at `line_start` and adds BIT_INC on every cycle in which the window is open. Each carry out gives one `bit_strobe` cycle. `bit_strobe` is only ever 1 while `ttx_gate` is 1, and exactly 360 strobes occur per eligible line. The window therefore lasts ceil(360*2^ACC_W/BIT_INC) cycles.
- R8: On each strobe, `ttx_bit_out` takes the value of `ttx_bit_in` sampled at that clock edge. It holds that value in all cycles without a strobe.
- R9: A `line_start` that arrives while a window is open ends the current line at once. Timing, bit count and accumulator restart from zero, and the new line gets a full 360-bit window if it is eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | LINE_W | Current line number, valid with `line_start` |
| field_odd | input | 1 | 1 = odd field, 0 = even field |
| odd_first | input | LINE_W | First insertion line, odd field |
| odd_last | input | LINE_W | Last insertion line, odd field |
| even_first | input | LINE_W | First insertion line, even field |
| even_last | input | LINE_W | Last insertion line, even field |
| ttx_bit_in | input | 1 | Serial teletext data |
| ttx_req | output | 1 | Data request to the teletext source |
| ttx_gate | output | 1 | Insertion window |
| bit_strobe | output | 1 | One-cycle strobe per teletext bit |
| ttx_bit_out | output | 1 | Data bit captured on the last strobe |

## Verification
Two events can land on the same edge: the 360th bit strobe and the closing of the request. When that happens, the window's final cycle coincides with a strobe while the request has already dropped. The bench counts, cycle by cycle, the indices where request, window and strobe are high. It compares the last window cycle and the request's fall against the closed-form window length. It also checks that no strobe falls outside the window.

A second collision is a new line start arriving while a window is open. This is provoked partway through a window, and the bench then requires a complete, correctly timed 360-bit window measured from the new pulse.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int unsigned TTX_BITS = 360;

  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ttx_line_qualify.sv
module ttx_line_qualify #(
  parameter int unsigned LINE_W = 10
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  output logic              eligible
);
  localparam int unsigned NFIELD = 2;

  logic [LINE_W-1:0] first_a [NFIELD];
  logic [LINE_W-1:0] last_a  [NFIELD];
  logic [NFIELD-1:0] hit;

  assign first_a[0] = even_first;
  assign last_a[0]  = even_last;
  assign first_a[1] = odd_first;
  assign last_a[1]  = odd_last;

  // An inverted range (first > last) can never satisfy both compares.
  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    assign hit[f] = (line_num >= first_a[f]) && (line_num <= last_a[f]);
  end

  assign eligible = field_odd ? hit[1] : hit[0];
endmodule

// File: rtl/ttx_bit_clock.sv
module ttx_bit_clock #(
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned BIT_INC = 16838
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic gate_n,
  output logic carry_n,
  output logic strobe_q
);
  localparam logic [ACC_W-1:0] INC_C = ACC_W'(BIT_INC);

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, INC_C};
    carry_n = gate_n && sum[ACC_W];
    if (line_start)  acc_n = '0;
    else if (gate_n) acc_n = sum[ACC_W-1:0];
    else             acc_n = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      acc_q    <= acc_n;
      strobe_q <= carry_n;
    end
  end

  // With a step of at most half the range, two carries can never be adjacent.
  if (BIT_INC <= (1 << (ACC_W - 1))) begin : g_gap_chk
    assert_strobe_gap_R7: assert property (@(posedge clk) disable iff (rst)
      strobe_q |=> !strobe_q)
      else $error("strobe on consecutive cycles");
  end
endmodule

// File: rtl/ttx_window_seq.sv
module ttx_window_seq #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned WIN_AT   = 64,
  parameter int unsigned REQ_LEAD = 8,
  parameter int unsigned NBITS    = ttx_pkg::TTX_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic eligible,
  input  logic carry_n,
  output logic gate_n,
  output logic req_q,
  output logic gate_q
);
  localparam int unsigned BIT_W = ttx_pkg::width_for(NBITS);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN_AT);
  localparam logic [CNT_W-1:0] REQ_C = CNT_W'(WIN_AT - REQ_LEAD);
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
  localparam logic [BIT_W-1:0] NB_C  = BIT_W'(NBITS);

  logic             active_q, active_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BIT_W-1:0] bits_q, bits_base, bits_n;
  logic             req_n;

  always_comb begin
    if (line_start) begin
      active_n  = eligible;
      cnt_n     = '0;
      bits_base = '0;
    end else begin
      active_n  = active_q;
      cnt_n     = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
      bits_base = bits_q;
    end
    gate_n = active_n && (cnt_n >= WIN_C) && (bits_base < NB_C) && !line_start;
    bits_n = bits_base + BIT_W'(gate_n && carry_n);
    req_n  = active_n && (cnt_n >= REQ_C) && (bits_n < NB_C);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= CMAX;
      bits_q   <= '0;
      req_q    <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      bits_q   <= bits_n;
      req_q    <= req_n;
      gate_q   <= gate_n;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    bits_q <= NB_C)
    else $error("bit count beyond window length");

  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (bits_q == '0) && !gate_q)
    else $error("line start did not restart the window");
endmodule

// File: rtl/ttx_line_inserter.sv
module ttx_line_inserter #(
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned WIN_AT   = 64,
  parameter int unsigned REQ_LEAD = 8,
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned BIT_INC  = 16838,
  parameter int unsigned NBITS    = ttx_pkg::TTX_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  input  logic              ttx_bit_in,
  output logic              ttx_req,
  output logic              ttx_gate,
  output logic              bit_strobe,
  output logic              ttx_bit_out
);
  logic eligible, gate_n, carry_n;

  ttx_line_qualify #(.LINE_W(LINE_W)) u_qual (
    .line_num(line_num), .field_odd(field_odd),
    .odd_first(odd_first), .odd_last(odd_last),
    .even_first(even_first), .even_last(even_last),
    .eligible(eligible)
  );

  ttx_window_seq #(
    .CNT_W(CNT_W), .WIN_AT(WIN_AT), .REQ_LEAD(REQ_LEAD), .NBITS(NBITS)
  ) u_seq (
    .clk(clk), .rst(rst), .line_start(line_start), .eligible(eligible),
    .carry_n(carry_n), .gate_n(gate_n), .req_q(ttx_req), .gate_q(ttx_gate)
  );

  ttx_bit_clock #(.ACC_W(ACC_W), .BIT_INC(BIT_INC)) u_clk (
    .clk(clk), .rst(rst), .line_start(line_start), .gate_n(gate_n),
    .carry_n(carry_n), .strobe_q(bit_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst)          ttx_bit_out <= 1'b0;
    else if (carry_n) ttx_bit_out <= ttx_bit_in;
  end

  assert_strobe_in_gate_R7: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> ttx_gate)
    else $error("strobe outside window");

  assert_gate_req_R5: assert property (@(posedge clk) disable iff (rst)
    (ttx_gate && !bit_strobe) |-> ttx_req)
    else $error("window open without request");

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !bit_strobe |-> $stable(ttx_bit_out))
    else $error("data changed without strobe");
endmodule

// File: tb/ttx_line_inserter_tb.sv
module ttx_line_inserter_tb_top;
  localparam int unsigned LINE_W   = 10;
  localparam int unsigned WIN_AT   = 64;
  localparam int unsigned REQ_LEAD = 8;
  localparam int unsigned ACC_W    = 16;
  localparam int unsigned BIT_INC  = 16838;
  localparam int unsigned NBITS    = 360;
  localparam int          LINE_CYC = 1600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic [LINE_W-1:0] line_num = '0;
  logic field_odd = 1'b1;
  logic [LINE_W-1:0] odd_first = 10'd7, odd_last = 10'd10;
  logic [LINE_W-1:0] even_first = 10'd320, even_last = 10'd322;
  logic ttx_bit_in = 1'b0;
  logic ttx_req, ttx_gate, bit_strobe, ttx_bit_out;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ttx_line_inserter dut_i (
    .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
    .field_odd(field_odd), .odd_first(odd_first), .odd_last(odd_last),
    .even_first(even_first), .even_last(even_last), .ttx_bit_in(ttx_bit_in),
    .ttx_req(ttx_req), .ttx_gate(ttx_gate), .bit_strobe(bit_strobe),
    .ttx_bit_out(ttx_bit_out)
  );

  function automatic logic patt(input int k);
    int v;
    v = k * 37 + 5;
    return v[3] ^ v[0];
  endfunction

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Pulses line_start, then observes LINE_CYC cycles indexed from the sampling edge.
  task automatic run_line(input int ln, input bit odd, input bit exp_on, input string tag);
    int req_first, req_last, gate_first, gate_last, strobes, stray, bad_bits, any_on;
    longint wl;
    int k;
    req_first = -1; req_last = -1; gate_first = -1; gate_last = -1;
    strobes = 0; stray = 0; bad_bits = 0; any_on = 0; k = 0;
    wl = (longint'(NBITS) * (longint'(1) << ACC_W) + BIT_INC - 1) / BIT_INC;
    @(negedge clk);
    line_num = LINE_W'(ln);
    field_odd = odd;
    line_start = 1'b1;
    ttx_bit_in = patt(0);
    for (int i = 0; i < LINE_CYC; i++) begin
      @(negedge clk);
      line_start = 1'b0;
      if (ttx_req) begin
        if (req_first < 0) req_first = i;
        req_last = i;
      end
      if (ttx_gate) begin
        if (gate_first < 0) gate_first = i;
        gate_last = i;
      end
      if (ttx_req || ttx_gate || bit_strobe) any_on++;
      if (bit_strobe) begin
        if (!ttx_gate) stray++;
        if (ttx_bit_out != patt(k)) bad_bits++;
        k++;
        strobes++;
        ttx_bit_in = patt(k);
      end
    end
    if (exp_on) begin
      check({tag, " R5 request first cycle"}, req_first, WIN_AT - REQ_LEAD);
      check({tag, " R5 request last cycle"}, req_last, WIN_AT + int'(wl) - 2);
      check({tag, " R6 window first cycle"}, gate_first, WIN_AT);
      check({tag, " R6 window last cycle"}, gate_last, WIN_AT + int'(wl) - 1);
      check({tag, " R7 strobe count"}, strobes, NBITS);
      check({tag, " R7 strobes outside window"}, stray, 0);
      check({tag, " R8 captured bit errors"}, bad_bits, 0);
    end else begin
      check({tag, " R4 activity on ineligible line"}, any_on, 0);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset", {ttx_req, ttx_gate, bit_strobe, ttx_bit_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", {ttx_req, ttx_gate, bit_strobe, ttx_bit_out}, 0);
  endtask

  task automatic t_odd_range;
    run_line(7, 1'b1, 1'b1, "R2 odd first line");
    run_line(10, 1'b1, 1'b1, "R2 odd last line");
    run_line(6, 1'b1, 1'b0, "R2 odd below range");
    run_line(11, 1'b1, 1'b0, "R2 odd above range");
  endtask

  task automatic t_even_range;
    run_line(322, 1'b0, 1'b1, "R2 even last line");
    run_line(8, 1'b0, 1'b0, "R2 odd-range line in even field");
  endtask

  task automatic t_inverted;
    even_first = 10'd330;
    even_last  = 10'd325;
    run_line(325, 1'b0, 1'b0, "R3 inverted even low");
    run_line(330, 1'b0, 1'b0, "R3 inverted even high");
    run_line(9, 1'b1, 1'b1, "R3 odd unaffected");
    even_first = 10'd320;
    even_last  = 10'd322;
  endtask

  task automatic t_restart;
    int gate_seen;
    @(negedge clk);
    line_num = 10'd9;
    field_odd = 1'b1;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (500) @(negedge clk);
    gate_seen = ttx_gate;
    check("R9 window open before restart", gate_seen, 1);
    run_line(9, 1'b1, 1'b1, "R9 restarted line");
  endtask

  initial begin
    t_reset();
    t_odd_range();
    t_even_range();
    t_inverted();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule